// File: doc/BRIEF.md
# Touch-Screen Digitizer Serial Control Front End

This block is the device-side serial port of a touch-screen digitizer converter. It samples a serial data line on every rising edge of the serial clock. While idle it throws away every bit until a 1 appears. That 1 opens an eight-bit command frame. The remaining seven bits carry a channel address, a resolution choice, a reference choice and a two-bit power-management code. All of these are decoded and presented as registered outputs for the analog side.

When the last command bit arrives, the block latches a parallel sample word to stand in for the converter result. It raises a busy flag for one clock. It then shifts the result out MSB first, one bit per falling clock edge. The result is 12 bits long, or 8 bits when the command asks for the short conversion. A new command may start while the previous result is still going out, but only at a fixed cadence after the previous start bit. A high level on the chip-select input returns the framer to its idle search and releases the output pad.

Top module: `touch_adc_link`

## Requirements
- R1: While searching for a frame, DIN bits of 0 have no effect; the first 1 sampled is taken as the start bit and becomes bit 7 of the command.
- R2: The seven bits that follow the start bit are, in order: address bits 2..0, the resolution bit, the reference bit, then power code bits 1..0. chanAddr, res8 and pdCode take these values at the rising edge that samples the last bit.
- R3: busy is high for exactly the one clock that follows the rising edge sampling the eighth command bit.
- R4: With resolution bit 0, all 12 bits of the latched sample (sampleIn captured at the eighth-bit edge) appear on dout MSB first. There is one bit per falling edge, and the first bit is driven at the falling edge that follows the busy clock.
- R5: With resolution bit 1, only sampleIn[11:4] are shifted out, MSB first, with the same timing.
- R6: While chip select is active and no result bit is being shifted, dout is 0.
- R7: Reference bit 1 selects single-ended (refSingle = 1). Reference bit 0 selects differential (refSingle = 0), which is allowed only for address 3'b101 (X position) and 3'b001 (Y position).
- R8: If differential is requested for any other address, refSingle is forced to 1 and refErr is set. refErr is set at the same edge busy rises, and it stays set, through chip-select cycling, until rst.
- R9: A new start bit is accepted no earlier than 15 clocks (12-bit frame) or 11 clocks (8-bit frame) after the previous start bit. A 1 sampled earlier than that is ignored, and the previous readout continues intact underneath an overlapping command.
- R10: While csn is high, doutOe is 0, busy stays low and any partly received command is discarded. After csn returns low, a start bit is accepted at once.
- R11: After rst, busy, dout, refErr, chanAddr, res8 and pdCode are 0 and refSingle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial data clock; DIN sampled on rising edge, dout updated on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | Chip select, active low; high idles the framer and releases dout |
| din | input | 1 | Serial command input |
| sampleIn | input | 12 | Parallel conversion result supplied from outside |
| dout | output | 1 | Serial result output, MSB first |
| doutOe | output | 1 | Output-pad enable for dout (0 = high impedance) |
| busy | output | 1 | One-clock conversion-in-progress flag |
| chanAddr | output | 3 | Decoded channel address |
| refSingle | output | 1 | 1 = single-ended reference, 0 = differential |
| res8 | output | 1 | 1 = 8-bit conversion, 0 = 12-bit |
| pdCode | output | 2 | Power-management code for an external decoder |
| refErr | output | 1 | Sticky flag: differential requested on a non-position channel |

## Verification
The hardest state to reach from the ports is a new command arriving at the exact cadence point while the previous result is still on dout. The same state must include a stray 1 that lands just before that point and has to be ignored. The stimulus is built as a timeline of back-to-back frames spaced 15 or 11 clocks apart, according to each frame's own resolution bit. A stray 1 is placed nine clocks after every start bit. Every clock of that timeline is compared against an expected dout and busy stream. The partly received command that chip select must discard is produced by a directed sequence that raises csn in the middle of a word.

// File: rtl/touch_adc_link_pkg.sv
package touch_adc_link_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CMD  = 2'd1,
    ST_BUSY = 2'd2
  } frameState_t;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic shiftIn;   // a command bit is on din this edge
    logic wordDone;  // this edge samples the last command bit
    logic loadOut;   // load the result shifter
    logic quiesce;   // chip deselected: clear the output path
  } ctrlStrobe_t;

endpackage

// File: rtl/touch_adc_link_ctrl.sv
module touch_adc_link_ctrl
  import touch_adc_link_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int PERIOD_HI = 15,
  parameter int PERIOD_LO = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csn,
  input  logic        din,
  input  logic        res8,
  output ctrlStrobe_t strb,
  output logic        busy
);

  localparam int CNT_W = $clog2(CMD_BITS);
  localparam int AGE_W = $clog2(PERIOD_HI + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(PERIOD_HI);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CMD_BITS - 2);

  frameState_t      state;
  logic [CNT_W-1:0] bitCnt;
  logic [AGE_W-1:0] startAge;
  logic [AGE_W-1:0] period;
  logic             startOk;
  logic             lastBit;

  assign period  = res8 ? AGE_W'(PERIOD_LO) : AGE_W'(PERIOD_HI);
  assign startOk = (state == ST_HUNT) && din && (startAge >= period);
  assign lastBit = (state == ST_CMD) && (bitCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst || csn) begin
      state    <= ST_HUNT;
      bitCnt   <= '0;
      startAge <= AGE_MAX;
    end else begin
      case (state)
        ST_HUNT: begin
          if (startOk) begin
            state  <= ST_CMD;
            bitCnt <= '0;
          end
        end
        ST_CMD: begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) state <= ST_BUSY;
        end
        ST_BUSY: state <= ST_HUNT;
        default: state <= ST_HUNT;
      endcase

      if (startOk)                startAge <= AGE_W'(1);
      else if (startAge != AGE_MAX) startAge <= startAge + 1'b1;
    end
  end

  assign strb.shiftIn  = (state == ST_CMD);
  assign strb.wordDone = lastBit;
  assign strb.loadOut  = (state == ST_BUSY);
  assign strb.quiesce  = csn;
  assign busy          = (state == ST_BUSY);

endmodule

// File: rtl/touch_adc_link_dpath.sv
module touch_adc_link_dpath
  import touch_adc_link_pkg::*;
#(
  parameter int          RES_HI   = 12,
  parameter int          RES_LO   = 8,
  parameter int          CMD_BITS = 8,
  parameter logic [2:0]  X_ADDR   = 3'b101,
  parameter logic [2:0]  Y_ADDR   = 3'b001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [RES_HI-1:0] sampleIn,
  input  ctrlStrobe_t       strb,
  output logic              dout,
  output logic [2:0]        chanAddr,
  output logic              refSingle,
  output logic              res8,
  output logic [1:0]        pdCode,
  output logic              refErr
);

  localparam int SH_W = CMD_BITS - 2;
  localparam int BL_W = $clog2(RES_HI + 1);

  logic [SH_W-1:0]   cmdShift;
  logic [SH_W:0]     word;
  logic [2:0]        wAddr;
  logic              wMode;
  logic              wRef;
  logic              isPos;
  logic [RES_HI-1:0] sampleHold;
  logic [RES_HI-1:0] outShift;
  logic [BL_W-1:0]   bitsLeft;

  assign word  = {cmdShift, din};
  assign wAddr = word[6:4];
  assign wMode = word[3];
  assign wRef  = word[2];
  assign isPos = (wAddr == X_ADDR) || (wAddr == Y_ADDR);

  // command capture and decode
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdShift   <= '0;
      chanAddr   <= '0;
      refSingle  <= 1'b1;
      res8       <= 1'b0;
      pdCode     <= '0;
      refErr     <= 1'b0;
      sampleHold <= '0;
    end else begin
      if (strb.shiftIn && !strb.wordDone)
        cmdShift <= {cmdShift[SH_W-2:0], din};
      if (strb.wordDone) begin
        chanAddr   <= wAddr;
        res8       <= wMode;
        pdCode     <= word[1:0];
        refSingle  <= wRef | ~isPos;
        sampleHold <= sampleIn;
        if (!wRef && !isPos) refErr <= 1'b1;
      end
    end
  end

  // result shifter
  always_ff @(posedge clk) begin
    if (rst || strb.quiesce) begin
      outShift <= '0;
      bitsLeft <= '0;
    end else if (strb.loadOut) begin
      outShift <= sampleHold;
      bitsLeft <= res8 ? BL_W'(RES_LO) : BL_W'(RES_HI);
    end else if (bitsLeft != '0) begin
      outShift <= {outShift[RES_HI-2:0], 1'b0};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  always_ff @(negedge clk) begin
    if (rst || strb.quiesce || bitsLeft == '0) dout <= 1'b0;
    else                                     dout <= outShift[RES_HI-1];
  end

endmodule

// File: rtl/touch_adc_link.sv
module touch_adc_link
  import touch_adc_link_pkg::*;
#(
  parameter int         RES_HI   = 12,
  parameter int         RES_LO   = 8,
  parameter int         CMD_BITS = 8,
  parameter logic [2:0] X_ADDR   = 3'b101,
  parameter logic [2:0] Y_ADDR   = 3'b001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn,
  input  logic              din,
  input  logic [RES_HI-1:0] sampleIn,
  output logic              dout,
  output logic              doutOe,
  output logic              busy,
  output logic [2:0]        chanAddr,
  output logic              refSingle,
  output logic              res8,
  output logic [1:0]        pdCode,
  output logic              refErr
);

  localparam int PERIOD_HI = RES_HI + 3;
  localparam int PERIOD_LO = RES_LO + 3;

  ctrlStrobe_t strb;

  touch_adc_link_ctrl #(
    .CMD_BITS (CMD_BITS),
    .PERIOD_HI(PERIOD_HI),
    .PERIOD_LO(PERIOD_LO)
  ) u_ctrl (
    .clk (clk),
    .rst (rst),
    .csn (csn),
    .din (din),
    .res8(res8),
    .strb(strb),
    .busy(busy)
  );

  touch_adc_link_dpath #(
    .RES_HI  (RES_HI),
    .RES_LO  (RES_LO),
    .CMD_BITS(CMD_BITS),
    .X_ADDR  (X_ADDR),
    .Y_ADDR  (Y_ADDR)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .sampleIn (sampleIn),
    .strb     (strb),
    .dout     (dout),
    .chanAddr (chanAddr),
    .refSingle(refSingle),
    .res8     (res8),
    .pdCode   (pdCode),
    .refErr   (refErr)
  );

  assign doutOe = ~csn;

endmodule

// File: rtl/touch_adc_link_chk.sv
module touch_adc_link_chk #(
  parameter logic [2:0] X_ADDR = 3'b101,
  parameter logic [2:0] Y_ADDR = 3'b001
) (
  input logic       clk,
  input logic       rst,
  input logic       csn,
  input logic       busy,
  input logic       refSingle,
  input logic       refErr,
  input logic [2:0] chanAddr
);

  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R3

  AST_DIFF_POS_ONLY: assert property (@(posedge clk) disable iff (rst)
    !refSingle |-> (chanAddr == X_ADDR || chanAddr == Y_ADDR)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    refErr |=> refErr); // R8

  AST_ERR_AT_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(refErr) |-> busy); // R8

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    csn |=> !busy); // R10

endmodule

bind touch_adc_link touch_adc_link_chk #(
  .X_ADDR(X_ADDR),
  .Y_ADDR(Y_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .csn      (csn),
  .busy     (busy),
  .refSingle(refSingle),
  .refErr   (refErr),
  .chanAddr (chanAddr)
);

// File: tb/sim_touch_adc_link.sv
module sim_touch_adc_link;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        rst, csn, din;
  logic [11:0] sampleIn;
  logic        dout, doutOe, busy, refSingle, res8, refErr;
  logic [2:0]  chanAddr;
  logic [1:0]  pdCode;

  touch_adc_link u0 (
    .clk(clk), .rst(rst), .csn(csn), .din(din), .sampleIn(sampleIn),
    .dout(dout), .doutOe(doutOe), .busy(busy), .chanAddr(chanAddr),
    .refSingle(refSingle), .res8(res8), .pdCode(pdCode), .refErr(refErr)
  );

  int errors = 0;
  int checks = 0;

  // {command word, sample, expected refSingle, expected refErr}
  localparam logic [21:0] VEC [8] = '{
    {8'hD0, 12'hA5C, 1'b0, 1'b0},  // X, 12-bit, differential
    {8'h99, 12'h3C7, 1'b0, 1'b0},  // Y, 8-bit, differential
    {8'hA6, 12'hF0F, 1'b1, 1'b0},  // ch2, 12-bit, single
    {8'h8F, 12'h81E, 1'b1, 1'b0},  // ch0, 8-bit, single
    {8'hB0, 12'h001, 1'b1, 1'b1},  // ch3 differential -> forced, error
    {8'hEC, 12'hFFF, 1'b1, 1'b1},  // ch6, 8-bit, error stays
    {8'hF5, 12'h800, 1'b1, 1'b1},  // ch7, 12-bit
    {8'hCA, 12'h7E3, 1'b1, 1'b1}   // ch4 differential, 8-bit -> forced
  };

  logic dinPlan [256];
  logic expDout [256];
  logic expBusy [256];
  int   frameAt [256];

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic d, input logic c);
    din = d;
    csn = c;
    @(posedge clk);
    #3;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s;
    int lastT;
    logic [7:0] w;
    logic [11:0] smp;
    logic [7:0] dw;
    logic [11:0] ds;

    for (int t = 0; t < 256; t++) begin
      dinPlan[t] = 1'b0; expDout[t] = 1'b0; expBusy[t] = 1'b0; frameAt[t] = -1;
    end

    // back-to-back frames at the cadence point, stray 1 nine clocks in (R9)
    s = 3;  // leading idle zeros (R1)
    for (int v = 0; v < 8; v++) begin
      w   = VEC[v][21:14];
      smp = VEC[v][13:2];
      frameAt[s] = v;
      for (int i = 0; i < 8; i++) dinPlan[s + i] = w[7 - i];
      expBusy[s + 7] = 1'b1;
      for (int j = 0; j < (w[3] ? 8 : 12); j++) expDout[s + 8 + j] = smp[11 - j];
      dinPlan[s + 9] = 1'b1;
      s = s + (w[3] ? 11 : 15);
    end
    lastT = s + 12;

    // reset state (R11)
    rst = 1'b1; csn = 1'b0; din = 1'b0; sampleIn = '0;
    repeat (3) @(posedge clk);
    #3;
    expect_eq("R11 busy", busy, 0);
    expect_eq("R11 dout", dout, 0);
    expect_eq("R11 refErr", refErr, 0);
    expect_eq("R11 chanAddr", chanAddr, 0);
    expect_eq("R11 refSingle", refSingle, 1);
    expect_eq("R11 res8", res8, 0);
    expect_eq("R11 pdCode", pdCode, 0);
    expect_eq("R10 doutOe selected", doutOe, 1);
    rst = 1'b0;

    for (int t = 0; t <= lastT; t++) begin
      if (frameAt[t] >= 0) sampleIn = VEC[frameAt[t]][13:2];
      tick(dinPlan[t], 1'b0);
      expect_eq("R1 R3 R9 busy", busy, expBusy[t]);
      expect_eq("R4 R5 R6 R9 dout", dout, expDout[t]);
      if (expBusy[t]) begin
        w = VEC[frameAt[t - 7]][21:14];
        expect_eq("R2 chanAddr", chanAddr, w[6:4]);
        expect_eq("R2 res8", res8, w[3]);
        expect_eq("R2 pdCode", pdCode, w[1:0]);
        expect_eq("R7 refSingle", refSingle, VEC[frameAt[t - 7]][1]);
        expect_eq("R8 refErr", refErr, VEC[frameAt[t - 7]][0]);
      end
    end

    // deselect: pad released, error sticky (R10, R8)
    tick(1'b0, 1'b1);
    expect_eq("R10 doutOe", doutOe, 0);
    expect_eq("R10 busy", busy, 0);
    expect_eq("R8 refErr across csn", refErr, 1);

    // partial command then deselect (R10)
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    expect_eq("R10 doutOe mid-word", doutOe, 0);

    dw = 8'hA6;
    ds = 12'h5A3;
    sampleIn = ds;
    for (int i = 0; i < 8; i++) tick(dw[7 - i], 1'b0);
    expect_eq("R10 busy fresh word", busy, 1);
    expect_eq("R10 chanAddr fresh word", chanAddr, 3'd2);
    expect_eq("R10 pdCode fresh word", pdCode, 2'd2);
    expect_eq("R10 res8 fresh word", res8, 0);
    for (int j = 0; j < 12; j++) begin
      tick(1'b0, 1'b0);
      expect_eq("R4 dout after reselect", dout, ds[11 - j]);
    end
    tick(1'b0, 1'b0);
    expect_eq("R6 dout idle", dout, 0);

    // only rst clears the sticky error (R8, R11)
    rst = 1'b1;
    tick(1'b0, 1'b0);
    rst = 1'b0;
    tick(1'b0, 1'b0);
    expect_eq("R8 refErr cleared by rst", refErr, 0);
    expect_eq("R11 refSingle after rst", refSingle, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule